// File: doc/BRIEF.md
# Microphone Clock, Sample-Rate Enable and Detection Interrupt Hub

This block sits at the top level of a multi-channel ultrasonic capture array and runs entirely from the system clock. It makes three timing signals. The first is a square-wave clock for the external PDM microphones. It is the system clock divided by an odd factor and still has an exact 50% duty cycle. The second is a single-cycle enable at that same bit rate, which the demodulators use. The third is a slower single-cycle enable at the PCM sample rate. Its period comes from a programmable divider value. With a 24 MHz system clock and the default settings, these are a 4.8 MHz microphone clock, a 4.8 MHz bit enable and a 480 kHz sample enable. The sample enable is ten bit periods long.

The block also collects the threshold-compare flags of all 36 channels into a status register. It drives three interrupt lines from that register. One line fires when any channel detects. The other two follow the first and the last channel of the array, so software can tell from which end a wavefront arrived on a linear array. A small write port sets the divider value. A read port returns the status flags as 16-bit words. The flags that do not fit in those words share a word with the divider value.

Top module: `timing_irq_hub`

## Requirements
- R1: While `rst_n` is low, `mclk`, `ce_pdm`, `ce_pcm` and `irq` are 0. Read words 0 and 1 return 0 and word 2 returns 0x0031 (divider default 49), whatever `cmp_in` holds.
- R2: `ce_pdm` is high for exactly one cycle in every 5. Its first pulse comes in the cycle after the fourth rising edge following reset release.
- R3: `mclk` has a period of 5 system clocks. Each high phase and each low phase lasts exactly 2.5 clocks.
- R4: With divider value P, `ce_pcm` is high for one cycle in every P+1. Its first pulse after reset comes in the cycle after the P-th rising edge.
- R5: A value written through `wr_en`/`wr_data` becomes the divider only at the next `ce_pcm` cycle, so the period in progress keeps its old length. A write in a `ce_pcm` cycle applies to the very next period.
- R6: While the default divider is in force, every `ce_pcm` pulse coincides with a `ce_pdm` pulse.
- R7: `cmp_in` is captured into the status register on each clock. `irq[0]` is the OR of all 36 captured flags, one cycle after the input.
- R8: `irq[1]` follows the captured flag of channel 0 and `irq[2]` follows the captured flag of channel 35, each one cycle after the input.
- R9: `rd_data` is a combinational read selected by `rd_addr`:
  - 0 returns channels 15..0 (channel 0 in bit 0).
  - 1 returns channels 31..16.
  - 2 returns the current pending divider value in bits 7..0 and channels 35..32 in bits 11..8, with bits 15..12 zero.
  - 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 36 | Threshold-compare flags, one per channel |
| wr_en | input | 1 | Divider write strobe |
| wr_data | input | 8 | New divider value |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 16 | Selected read word |
| mclk | output | 1 | 50% duty microphone clock |
| ce_pdm | output | 1 | Bit-rate clock enable |
| ce_pcm | output | 1 | Sample-rate clock enable |
| irq | output | 3 | Any-channel, first-channel and last-channel detection |

## Verification
A wrong bit-counter state shows up as a `ce_pdm` gap other than five cycles, or as an `mclk` phase of the wrong length, within one microphone period. A corrupted divider count or limit moves the next `ce_pcm` edge, so it shows up within one sample period. Loading the limit at the wrong time changes the length of the period that was in progress when the write arrived. A wrong status register shows on `irq` and on `rd_data` in the very next cycle. The bench compares every output against a behavioural model on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/hub_pkg.sv
package hub_pkg;
    typedef enum logic [1:0] {
        RD_CH_LO  = 2'd0,
        RD_CH_MID = 2'd1,
        RD_PS_TOP = 2'd2,
        RD_EMPTY  = 2'd3
    } rd_sel_e;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/hub_mclk_gen.sv
module hub_mclk_gen #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic mclk,
    output logic ce_pdm
);
    localparam int CW = hub_pkg::cnt_width(DIV);
    localparam int HI = (DIV + 1) / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pos;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(DIV - 1)) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.pos = (s_d.cnt < CW'(HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.pos <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ce_pdm = (s_q.cnt == CW'(DIV - 1));

    generate
        if (DIV % 2 == 1) begin : g_odd
            logic neg_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    neg_q <= 1'b0;
                end else begin
                    neg_q <= s_q.pos;
                end
            end
            assign mclk = s_q.pos & neg_q;
        end else begin : g_even
            assign mclk = s_q.pos;
        end
    endgenerate
endmodule

// File: rtl/hub_pcm_tick.sv
module hub_pcm_tick #(
    parameter int          PS_W   = 8,
    parameter logic [7:0]  PS_RST = 8'd49
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PS_W-1:0] wr_val,
    output logic [PS_W-1:0] pend_o,
    output logic            ce_pcm
);
    typedef struct packed {
        logic [PS_W-1:0] cnt;
        logic [PS_W-1:0] lim;
        logic [PS_W-1:0] pend;
    } st_t;

    st_t  s_d, s_q;
    logic wrap;

    assign wrap = (s_q.cnt == s_q.lim);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.pend = wr_val;
        end
        if (wrap) begin
            s_d.cnt = '0;
            s_d.lim = s_d.pend;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.lim  <= PS_W'(PS_RST);
            s_q.pend <= PS_W'(PS_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign ce_pcm = wrap;
    assign pend_o = s_q.pend;
endmodule

// File: rtl/hub_status.sv
module hub_status #(
    parameter int NCH    = 36,
    parameter int WORD_W = 16,
    parameter int PS_W   = 8,
    parameter int AW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cmp_in,
    input  logic [PS_W-1:0]   ps_val,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [2:0]        irq
);
    localparam int NFULL = NCH / WORD_W;
    localparam int REM   = NCH - NFULL * WORD_W;
    localparam int NWORD = NFULL + 1;
    localparam int PADW  = WORD_W - PS_W - REM;

    typedef struct packed {
        logic [NCH-1:0] stat;
    } st_t;

    st_t               s_d, s_q;
    logic [WORD_W-1:0] words [NWORD];

    always_comb begin
        s_d      = s_q;
        s_d.stat = cmp_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        for (genvar w = 0; w < NFULL; w++) begin : g_word
            assign words[w] = s_q.stat[w*WORD_W +: WORD_W];
        end
        if (REM > 0) begin : g_tail
            assign words[NFULL] = {{PADW{1'b0}}, s_q.stat[NCH-1 -: REM], ps_val};
        end else begin : g_notail
            assign words[NFULL] = {{(WORD_W-PS_W){1'b0}}, ps_val};
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NWORD; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = words[i];
            end
        end
    end

    assign irq[0] = |s_q.stat;
    assign irq[1] = s_q.stat[0];
    assign irq[2] = s_q.stat[NCH-1];
endmodule

// File: rtl/timing_irq_hub.sv
module timing_irq_hub #(
    parameter int         NCH     = 36,
    parameter int         PDM_DIV = 5,
    parameter int         PS_W    = 8,
    parameter logic [7:0] PS_RST  = 8'd49,
    parameter int         WORD_W  = 16,
    parameter int         AW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cmp_in,
    input  logic              wr_en,
    input  logic [PS_W-1:0]   wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              mclk,
    output logic              ce_pdm,
    output logic              ce_pcm,
    output logic [2:0]        irq
);
    logic [PS_W-1:0] ps_pend;

    hub_mclk_gen #(.DIV(PDM_DIV)) u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .mclk   (mclk),
        .ce_pdm (ce_pdm)
    );

    hub_pcm_tick #(.PS_W(PS_W), .PS_RST(PS_RST)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_val (wr_data),
        .pend_o (ps_pend),
        .ce_pcm (ce_pcm)
    );

    hub_status #(.NCH(NCH), .WORD_W(WORD_W), .PS_W(PS_W), .AW(AW)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_in  (cmp_in),
        .ps_val  (ps_pend),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );
endmodule

// File: rtl/hub_checker.sv
module hub_checker #(
    parameter int NCH = 36,
    parameter int DIV = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cmp_in,
    input logic           wr_en,
    input logic           ce_pdm,
    input logic           ce_pcm,
    input logic [2:0]     irq
);
    localparam int GW = $clog2(DIV + 1) + 1;

    logic [GW-1:0] gap_q;
    logic          wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            wrote_q <= 1'b0;
        end else begin
            gap_q   <= ce_pdm ? '0 : gap_q + 1'b1;
            wrote_q <= wrote_q | wr_en;
        end
    end

    p_pdm_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pdm |-> (gap_q == GW'(DIV - 1)));
    p_pdm_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GW'(DIV - 1)) |-> ce_pdm);
    p_pdm_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pdm |=> !ce_pdm);
    p_pcm_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrote_q && ce_pcm) |-> ce_pdm);
    p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq[0] == (|$past(cmp_in))));
    p_irq_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq[1] == $past(cmp_in[0])));
    p_irq_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq[2] == $past(cmp_in[NCH-1])));
endmodule

bind timing_irq_hub hub_checker #(.NCH(NCH), .DIV(PDM_DIV)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_in (cmp_in),
    .wr_en  (wr_en),
    .ce_pdm (ce_pdm),
    .ce_pcm (ce_pcm),
    .irq    (irq)
);

// File: tb/timing_irq_hub_test.sv
module timing_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] cmp_in = '1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [15:0] rd_data;
    logic        mclk, ce_pdm, ce_pcm;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int          m_pdm = 0;
    int          m_cnt = 0;
    logic [7:0]  m_lim = 8'd49;
    logic [7:0]  m_pend = 8'd49;
    logic [35:0] m_stat = '0;
    bit          m_written = 0;

    always #2 clk = ~clk;

    timing_irq_hub uut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mclk(mclk), .ce_pdm(ce_pdm), .ce_pcm(ce_pcm), .irq(irq)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_stat[15:0];
            2'd1:    return m_stat[31:16];
            2'd2:    return {4'b0, m_stat[35:32], m_pend};
            default: return 16'h0000;
        endcase
    endfunction

    // Behavioural reference, compared one time unit after every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pdm = 0; m_cnt = 0; m_lim = 8'd49; m_pend = 8'd49; m_stat = '0;
            m_written = 0;
        end else begin
            m_pdm = (m_pdm == 4) ? 0 : m_pdm + 1;
            if (wr_en) begin
                m_pend = wr_data;
                m_written = 1;
            end
            if (m_cnt == int'(m_lim)) begin
                m_cnt = 0;
                m_lim = m_pend;
            end else begin
                m_cnt++;
            end
            m_stat = cmp_in;
        end
        #1;
        if (!done) begin
            chk(ce_pdm == (m_pdm == 4), "R2 ce_pdm", ce_pdm, m_pdm == 4);
            chk(ce_pcm == (m_cnt == int'(m_lim)), "R4/R5 ce_pcm", ce_pcm, m_cnt == int'(m_lim));
            chk(irq[0] == (|m_stat), "R7 irq0", irq[0], |m_stat);
            chk(irq[1] == m_stat[0], "R8 irq1", irq[1], m_stat[0]);
            chk(irq[2] == m_stat[35], "R8 irq2", irq[2], m_stat[35]);
            chk(rd_data == exp_rd(rd_addr), "R9 rd_data", rd_data, exp_rd(rd_addr));
            if (rst_n && !m_written && ce_pcm)
                chk(ce_pdm == 1'b1, "R6 alignment", ce_pdm, 1);
        end
    end

    // mclk run lengths measured in half-clock samples
    int mrun = 0;
    logic mprev = 1'b0;
    bit mseen = 0;
    always @(posedge clk or negedge clk) begin
        #1;
        if (!done) begin
            if (!rst_n) begin
                chk(mclk == 1'b0, "R1 mclk in reset", mclk, 0);
                mrun = 0; mprev = 1'b0; mseen = 0;
            end else if (mclk == mprev) begin
                mrun++;
            end else begin
                if (mprev) chk(mrun == 5, "R3 mclk high half-cycles", mrun, 5);
                else if (mseen) chk(mrun == 5, "R3 mclk low half-cycles", mrun, 5);
                if (mclk) mseen = 1;
                mprev = mclk;
                mrun = 1;
            end
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic write_ps(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        cyc(3);
        // R1: reset state with all compare flags asserted
        chk(rd_data == 16'h0031, "R1 word2 reset", rd_data, 16'h0031);
        rd_addr = 2'd0; #0.5;
        chk(rd_data == 16'h0000, "R1 word0 reset", rd_data, 0);
        rd_addr = 2'd1; #0.5;
        chk(rd_data == 16'h0000, "R1 word1 reset", rd_data, 0);
        chk(irq == 3'b000, "R1 irq reset", irq, 0);
        chk({ce_pdm, ce_pcm} == 2'b00, "R1 enables reset", {ce_pdm, ce_pcm}, 0);
        cyc(2);
        cmp_in = '0;
        rst_n = 1'b1;
        for (int i = 0; i < 130; i++) begin
            rd_addr = 2'(i);
            cyc(1);
        end
        // R7 R8 R9: compare-flag patterns
        cmp_in = 36'h1;           cyc(3);
        cmp_in = 36'h8_0000_0000; cyc(3);
        cmp_in = 36'h0_0002_0000; rd_addr = 2'd1; cyc(3);
        cmp_in = 36'h2_0000_0000; rd_addr = 2'd2; cyc(3);
        cmp_in = '1;              rd_addr = 2'd3; cyc(3);
        cmp_in = '0;              cyc(3);
        for (int i = 0; i < 40; i++) begin
            cmp_in = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            rd_addr = 2'($urandom);
            cyc(1);
        end
        cmp_in = '0;
        // R5: writes mid-period, immediately, and in a wrap cycle
        wait (m_cnt == 10); @(negedge clk);
        write_ps(8'd9);   cyc(100);
        write_ps(8'd3);   cyc(40);
        write_ps(8'd0);   cyc(10);
        write_ps(8'd12);  cyc(5);
        while (m_cnt != int'(m_lim)) @(negedge clk);
        write_ps(8'd6);   cyc(40);
        rd_addr = 2'd2;
        write_ps(8'd255); cyc(600);
        // R1: reset again mid-run
        rst_n = 1'b0; cmp_in = '1; cyc(3);
        chk(rd_data == 16'h0031, "R1 word2 after re-reset", rd_data, 16'h0031);
        rst_n = 1'b1; cmp_in = '0; cyc(80);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule